// File: doc/BRIEF.md
# Dual-Count PWM Generator

This block drives one pulse-width-modulated output. The active and inactive halves of each period are set independently by two 16-bit counts, so the duty cycle and the frequency are both set by those two numbers. A 4-bit prescaler sets the counting rate. The prescaler divides one of two single-cycle tick enables, a fast one and a slow one, which are both synchronous to the system clock. A configuration bit picks which tick enable is used.

Software sees three registers on a plain write port with a combinational read port. A configuration register holds the run bit, the polarity bit, the source select and the prescale value. Two count registers stage the next active and inactive lengths. Staged counts reach the running counter only when an inactive phase completes, so a period is never torn by a count update. A prescale change takes effect at the next tick. A zero count pins the output at a static level instead of producing pulses.

Top module: `pwm_dual_count`

## Requirements
- R1: After reset, every register reads zero and `pwm_out` is low.
- R2: Register map, as seen on the read port at the same address. Address 0 is the configuration register: bit 0 enables, bit 1 inverts, bit 2 selects the slow tick, and bits 7:4 hold the prescale value. Address 1 holds the staged active count and address 2 the staged inactive count. Address 3 reads zero.
- R3: Running with counts A and B both nonzero and prescale P, each active phase lasts (P+1)*(A+1) selected ticks and each inactive phase lasts (P+1)*(B+1) selected ticks.
- R4: Only ticks from the selected source advance the generator. Ticks on the other source have no effect on phase lengths.
- R5: The active level is high when the invert bit is 0 and low when it is 1. The inactive level is the opposite.
- R6: When the working active count is nonzero and the working inactive count is zero, the output stays at the active level.
- R7: When the working active count is zero, the output stays at the inactive level. This includes the case where both counts are zero.
- R8: Count writes made during a period do not alter that period. They apply from the active phase that follows the end of the current inactive phase.
- R9: A prescale write alters the counting rate from the next selected tick, without waiting for a period boundary.
- R10: While disabled, the output is at the inactive level. On enable, an active phase of the latest staged length starts in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fast_tick | input | 1 | Fast count-source enable, one cycle wide |
| slow_tick | input | 1 | Slow count-source enable, one cycle wide |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for write and read |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| pwm_out | output | 1 | PWM output |

## Verification
The bench measures run lengths on `pwm_out` and compares them with the length formula over random counts, prescale values, tick spacings, sources and polarities. A design that counted only A ticks, or that was off by one on the prescaler, would fail those checks by a fixed amount.

Count writes are made in the middle of an active phase, and the bench expects the old lengths for the rest of that period. A design that applied writes at once would give a shortened or stretched active phase. A prescale cut in mid-phase must shorten that same phase; a design that held the prescale until the boundary would stretch it about eightfold.

The bench also covers the zero-count static levels under both polarities and the start of the first phase on enable. It runs a slow source with fast ticks present, which exposes a source mux that leaks the unselected ticks.

// File: rtl/pwm_dc_pkg.sv
package pwm_dc_pkg;
  typedef enum logic [1:0] {
    ADDR_CFG = 2'd0,
    ADDR_ON  = 2'd1,
    ADDR_OFF = 2'd2,
    ADDR_NUL = 2'd3
  } reg_addr_e;

  localparam int CFG_EN_BIT  = 0;
  localparam int CFG_INV_BIT = 1;
  localparam int CFG_SRC_BIT = 2;
  localparam int CFG_PS_LSB  = 4;

  typedef enum logic {
    PH_ON  = 1'b0,
    PH_OFF = 1'b1
  } phase_e;
endpackage

// File: rtl/pwm_dc_regs.sv
module pwm_dc_regs
  import pwm_dc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16,
  parameter int PS_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              cfg_en,
  output logic              cfg_inv,
  output logic              cfg_slow,
  output logic [PS_W-1:0]   cfg_ps,
  output logic [CNT_W-1:0]  stage_on,
  output logic [CNT_W-1:0]  stage_off
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_en    <= 1'b0;
      cfg_inv   <= 1'b0;
      cfg_slow  <= 1'b0;
      cfg_ps    <= '0;
      stage_on  <= '0;
      stage_off <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        ADDR_CFG: begin
          cfg_en   <= reg_wdata[CFG_EN_BIT];
          cfg_inv  <= reg_wdata[CFG_INV_BIT];
          cfg_slow <= reg_wdata[CFG_SRC_BIT];
          cfg_ps   <= reg_wdata[CFG_PS_LSB +: PS_W];
        end
        ADDR_ON:  stage_on  <= reg_wdata[CNT_W-1:0];
        ADDR_OFF: stage_off <= reg_wdata[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_CFG: begin
        reg_rdata[CFG_EN_BIT]          = cfg_en;
        reg_rdata[CFG_INV_BIT]         = cfg_inv;
        reg_rdata[CFG_SRC_BIT]         = cfg_slow;
        reg_rdata[CFG_PS_LSB +: PS_W]  = cfg_ps;
      end
      ADDR_ON:  reg_rdata = DATA_W'(stage_on);
      ADDR_OFF: reg_rdata = DATA_W'(stage_off);
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pwm_dc_prescaler.sv
module pwm_dc_prescaler #(
  parameter int PS_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            slow_sel,
  input  logic            fast_tick,
  input  logic            slow_tick,
  input  logic [PS_W-1:0] ps,
  output logic            step
);
  logic [PS_W-1:0] pcnt;
  logic            src_tick;
  logic            wrap;

  assign src_tick = slow_sel ? slow_tick : fast_tick;
  // Compare with >= so that a lowered prescale wraps on the next tick
  assign wrap = (pcnt >= ps);
  assign step = en & src_tick & wrap;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      pcnt <= '0;
    end else if (src_tick) begin
      pcnt <= wrap ? '0 : pcnt + 1'b1;
    end
  end
endmodule

// File: rtl/pwm_dc_phase.sv
module pwm_dc_phase
  import pwm_dc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             step,
  input  logic [CNT_W-1:0] stage_on,
  input  logic [CNT_W-1:0] stage_off,
  output phase_e           phase,
  output logic [CNT_W-1:0] work_on,
  output logic [CNT_W-1:0] work_off,
  output logic [CNT_W-1:0] ccnt,
  output logic             off_done
);
  logic [CNT_W-1:0] limit;
  logic             at_limit;

  assign limit    = (phase == PH_ON) ? work_on : work_off;
  assign at_limit = (ccnt == limit);
  assign off_done = step & at_limit & (phase == PH_OFF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_ON;
      ccnt     <= '0;
      work_on  <= '0;
      work_off <= '0;
    end else if (!en) begin
      phase    <= PH_ON;
      ccnt     <= '0;
      work_on  <= stage_on;
      work_off <= stage_off;
    end else if (step) begin
      if (at_limit) begin
        ccnt <= '0;
        if (phase == PH_ON) begin
          phase <= PH_OFF;
        end else begin
          phase    <= PH_ON;
          work_on  <= stage_on;
          work_off <= stage_off;
        end
      end else begin
        ccnt <= ccnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwm_dual_count.sv
module pwm_dual_count
  import pwm_dc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16,
  parameter int PS_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fast_tick,
  input  logic              slow_tick,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              pwm_out
);
  logic             cfg_en;
  logic             cfg_inv;
  logic             cfg_slow;
  logic [PS_W-1:0]  cfg_ps;
  logic [CNT_W-1:0] stage_on;
  logic [CNT_W-1:0] stage_off;
  logic             step;
  phase_e           phase;
  logic [CNT_W-1:0] work_on;
  logic [CNT_W-1:0] work_off;
  logic [CNT_W-1:0] ccnt;
  logic             off_done;
  logic             force_act;
  logic             force_idle;
  logic             active;

  pwm_dc_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .PS_W(PS_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cfg_en(cfg_en),
    .cfg_inv(cfg_inv), .cfg_slow(cfg_slow), .cfg_ps(cfg_ps),
    .stage_on(stage_on), .stage_off(stage_off)
  );

  pwm_dc_prescaler #(.PS_W(PS_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .en(cfg_en), .slow_sel(cfg_slow),
    .fast_tick(fast_tick), .slow_tick(slow_tick), .ps(cfg_ps), .step(step)
  );

  pwm_dc_phase #(.CNT_W(CNT_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .en(cfg_en), .step(step),
    .stage_on(stage_on), .stage_off(stage_off), .phase(phase),
    .work_on(work_on), .work_off(work_off), .ccnt(ccnt), .off_done(off_done)
  );

  assign force_idle = (work_on == '0);
  assign force_act  = !force_idle && (work_off == '0);
  assign active     = force_act | (!force_idle & (phase == PH_ON));
  assign pwm_out    = (cfg_en & active) ^ cfg_inv;
endmodule

// File: rtl/pwm_dual_count_chk.sv
module pwm_dual_count_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_en,
  input logic             cfg_inv,
  input logic             cfg_slow,
  input logic             fast_tick,
  input logic             slow_tick,
  input logic             step,
  input logic             phase,
  input logic [CNT_W-1:0] work_on,
  input logic [CNT_W-1:0] work_off,
  input logic [CNT_W-1:0] ccnt,
  input logic             off_done,
  input logic             pwm_out
);
  // R4
  step_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (cfg_slow ? slow_tick : fast_tick));

  // R6
  force_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && work_on != '0 && work_off == '0) |-> (pwm_out == !cfg_inv));

  // R7
  force_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && work_on == '0) |-> (pwm_out == cfg_inv));

  // R8
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && $past(cfg_en) && !$past(off_done)) |->
      ($stable(work_on) && $stable(work_off)));

  // R3
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ccnt <= (phase ? work_off : work_on));

  // R10
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |-> (pwm_out == cfg_inv));
endmodule

bind pwm_dual_count pwm_dual_count_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_inv(cfg_inv),
  .cfg_slow(cfg_slow), .fast_tick(fast_tick), .slow_tick(slow_tick),
  .step(step), .phase(phase), .work_on(work_on), .work_off(work_off),
  .ccnt(ccnt), .off_done(off_done), .pwm_out(pwm_out)
);

// File: tb/sim_pwm_dual_count.sv
`timescale 1ns/1ps
module sim_pwm_dual_count;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fast_tick = 1'b0;
  logic        slow_tick = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic        pwm_out;

  int total = 0;
  int fails = 0;
  int fast_div = 1;
  int slow_div = 3;
  int fc = 0;
  int sc = 0;

  pwm_dual_count u0 (
    .clk(clk), .rst_n(rst_n), .fast_tick(fast_tick), .slow_tick(slow_tick),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pwm_out(pwm_out)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (fc >= fast_div - 1) fc = 0; else fc = fc + 1;
    if (sc >= slow_div - 1) sc = 0; else sc = sc + 1;
    fast_tick = (fc == 0);
    slow_tick = (sc == 0);
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int phase_len(int div, int ps, int cnt);
    return div * (ps + 1) * (cnt + 1);
  endfunction

  function automatic logic [15:0] cfg_word(bit en, bit inv, bit slow, int ps);
    return {8'd0, 4'(ps), 1'b0, slow, inv, en};
  endfunction

  task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
    reg_addr  = a;
    reg_wdata = d;
    reg_we    = 1'b1;
    @(negedge clk);
    reg_we    = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output int v);
    reg_addr = a;
    #1;
    v = int'(reg_rdata);
  endtask

  task automatic skip(input logic lvl);
    for (int i = 0; i < 20000 && pwm_out == lvl; i++) @(negedge clk);
  endtask

  task automatic count_run(input logic lvl, output int n);
    n = 0;
    while (pwm_out == lvl && n < 20000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic setup(input int on, input int off, input bit inv, input bit slow, input int ps);
    reg_write(2'd0, cfg_word(1'b0, inv, slow, ps));
    reg_write(2'd1, 16'(on));
    reg_write(2'd2, 16'(off));
    reg_write(2'd0, cfg_word(1'b1, inv, slow, ps));
  endtask

  task automatic hold_check(input string req, input logic lvl, input int cycles);
    int bad;
    bad = 0;
    for (int i = 0; i < cycles; i++) begin
      if (pwm_out != lvl) bad++;
      @(negedge clk);
    end
    chk(req, bad, 0);
  endtask

  initial begin
    int v, n, a, b, exp_hi;
    int on, off, ps, dv;
    bit inv, slow;
    logic act;
    v = int'($urandom(32'd4242));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 pwm_out", int'(pwm_out), 0);
    reg_read(2'd0, v); chk("R1 cfg", v, 0);
    reg_read(2'd1, v); chk("R1 on", v, 0);
    reg_read(2'd2, v); chk("R1 off", v, 0);

    // R2: field placement and readback
    reg_write(2'd0, cfg_word(1'b0, 1'b1, 1'b1, 5));
    reg_write(2'd1, 16'hBEEF);
    reg_write(2'd2, 16'h1234);
    reg_read(2'd0, v); chk("R2 cfg", v, 16'h0056);
    reg_read(2'd1, v); chk("R2 on", v, 16'hBEEF);
    reg_read(2'd2, v); chk("R2 off", v, 16'h1234);
    reg_read(2'd3, v); chk("R2 unused", v, 0);
    // R10, R5: disabled with invert set sits high
    chk("R10 idle inverted", int'(pwm_out), 1);

    // R10: first active phase starts right after enable
    fast_div = 1;
    reg_write(2'd0, cfg_word(1'b0, 1'b0, 1'b0, 1));
    reg_write(2'd1, 16'd4);
    reg_write(2'd2, 16'd2);
    reg_write(2'd0, cfg_word(1'b1, 1'b0, 1'b0, 1));
    count_run(1'b1, n); chk("R10 first phase", n, phase_len(1, 1, 4));
    count_run(1'b0, n); chk("R3 first off", n, phase_len(1, 1, 2));

    // R3, R4, R5: random patterns
    for (int it = 0; it < 8; it++) begin
      on   = 1 + int'($urandom_range(11));
      off  = 1 + int'($urandom_range(11));
      ps   = int'($urandom_range(3));
      inv  = 1'($urandom_range(1));
      slow = 1'($urandom_range(1));
      fast_div = 1 + int'($urandom_range(1));
      slow_div = 2 + int'($urandom_range(2));
      dv = slow ? slow_div : fast_div;
      act = ~inv;
      setup(on, off, inv, slow, ps);
      skip(act); skip(~act);
      count_run(act, a);
      count_run(~act, b);
      chk(slow ? "R4 R3 active slow" : "R3 active fast", a, phase_len(dv, ps, on));
      chk(inv ? "R5 R3 inactive inverted" : "R3 inactive", b, phase_len(dv, ps, off));
    end

    // R4: slow source with fast ticks every cycle
    fast_div = 1; slow_div = 4;
    setup(2, 3, 1'b0, 1'b1, 0);
    skip(1'b1); skip(1'b0);
    count_run(1'b1, a); chk("R4 slow active", a, 12);
    count_run(1'b0, b); chk("R4 slow inactive", b, 16);

    // R8: count writes mid-period apply after the inactive phase
    setup(6, 4, 1'b0, 1'b0, 0);
    skip(1'b1); skip(1'b0);
    reg_write(2'd1, 16'd12);
    reg_write(2'd2, 16'd9);
    count_run(1'b1, n); chk("R8 current active", n + 2, 7);
    count_run(1'b0, n); chk("R8 current inactive", n, 5);
    count_run(1'b1, n); chk("R8 next active", n, 13);
    count_run(1'b0, n); chk("R8 next inactive", n, 10);

    // R9: prescale cut mid-phase shortens the same phase
    setup(40, 5, 1'b0, 1'b0, 7);
    skip(1'b1); skip(1'b0);
    reg_write(2'd0, cfg_word(1'b1, 1'b0, 1'b0, 0));
    count_run(1'b1, n);
    exp_hi = n + 1;
    chk("R9 shortened phase", int'(exp_hi >= 41 && exp_hi <= 60), 1);
    count_run(1'b0, n); chk("R9 next inactive", n, 6);

    // R6: forced active, both polarities
    setup(5, 0, 1'b0, 1'b0, 0);
    @(negedge clk);
    hold_check("R6 forced high", 1'b1, 100);
    setup(5, 0, 1'b1, 1'b0, 2);
    @(negedge clk);
    hold_check("R6 R5 forced active inverted", 1'b0, 100);

    // R7: forced inactive and both zero
    setup(0, 5, 1'b0, 1'b0, 0);
    @(negedge clk);
    hold_check("R7 forced low", 1'b0, 100);
    setup(0, 0, 1'b1, 1'b0, 0);
    @(negedge clk);
    hold_check("R7 both zero inverted", 1'b1, 100);

    // R10: disable while running
    setup(3, 3, 1'b0, 1'b0, 0);
    skip(1'b0);
    reg_write(2'd0, cfg_word(1'b0, 1'b0, 1'b0, 0));
    hold_check("R10 disabled", 1'b0, 40);

    $display("  %0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  %0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule